// File: doc/BRIEF.md
# Audio Codec Control Register File

This block keeps the mixer and configuration state of an audio codec. A controller issues commands made of a 7-bit register index and a 16-bit data word, with a write strobe or a read strobe. Each implemented register has its own reset default and a write mask. Bits outside the mask read as zero and cannot be changed. A few registers behave differently. Index 00h holds no storage: writing any value to it restores the whole file, and reading it returns a fixed capability word. The power register merges live subsystem-ready inputs into its low byte. The extended-ID register reflects the two codec-ID pins. The stereo-enhance depth register is fixed at zero.

Beside the read port, the block drives the decoded control fields to the analog and rate-conversion logic. These are the volume words, the record gain, the left and right record source, the general-purpose mode bits, the variable-rate enable, the DAC and ADC sample rates, and the powerdown controls. A two-state read FSM handles reads. `ST_IDLE` moves to `ST_RESP` when a read strobe is seen (transition *issue*). `ST_RESP` stays in `ST_RESP` on a back-to-back read (*chain*) and otherwise returns to `ST_IDLE` (*retire*). `ST_IDLE` with no read strobe stays put (*wait*). `rd_valid` is high exactly while the FSM is in `ST_RESP`.

Top module: `codec_ctrl_regs`

## Requirements
- R1: After hard reset these registers read as follows: 02h=8008h, 06h=8000h, 0Ah=0000h, 0Ch=8008h, 0Eh=8008h, 10h=8808h, 12h=8808h, 18h=8808h, 1Ah=0000h, 1Ch=8000h, 20h=0000h, 2Ch=BB80h and 32h=BB80h.
- R2: A write of any value to index 00h returns every register to its R1 default in the same cycle. A read of 00h returns 0D50h.
- R3: Each register keeps only its writable bits and reads 0 elsewhere. The writable masks are: 02h/10h/12h/18h 9F1Fh, 06h/0Ch 801Fh, 0Ah 801Eh, 0Eh 805Fh, 1Ah 0707h, 1Ch 8F0Fh, 20h A380h, 2Ch/32h FFFFh.
- R4: For register 26h, bits 14:8 are writable powerdown controls and drive `pwrdn`. Bits 3:0 read the live `ready_in[3:0]` (bit 3 reference, 2 mixer, 1 DAC, 0 ADC). Writes to the low byte are ignored.
- R5: Register 28h is read-only. It reads {id_pins[1], id_pins[0]} in bits 15:14, 1 in bit 0, and 0 elsewhere.
- R6: In register 2Ah only bit 0 is writable. It drives `vra_en`, and the register reads 000Xh.
- R7: Register 22h ignores writes and always reads 0000h.
- R8: Odd indices and unlisted even indices read 0000h. Writes to them change no register and no control output.
- R9: `rd_valid` is high in the cycle after each cycle with `rd_en` and low otherwise. `rd_data` then holds the register value as it stood before any write made in the same cycle as the read.
- R10: Decoded outputs are driven as follows. `rec_sel_l`/`rec_sel_r` come from 1Ah bits 10:8 and 2:0. From 20h: `pcm_post_enh` is bit 15, `enh_en` bit 13, `mono_src_mic` bit 9, `mic_src_2` bit 8 and `adc_dac_loop` bit 7. `dac_rate` is 2Ch and `adc_rate` is 32h.
- R11: The volume outputs equal the stored contents of 02h, 06h, 0Ah, 0Ch, 0Eh, 10h, 12h, 18h and 1Ch, and change on the clock edge of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| idx | input | 7 | Register index |
| wdata | input | 16 | Write data |
| id_pins | input | 2 | Codec ID pins (bit 1 high-order) |
| ready_in | input | 4 | Subsystem ready flags |
| rd_data | output | 16 | Read result |
| rd_valid | output | 1 | Read result valid |
| vol_master | output | 16 | Line output volume word |
| vol_mono | output | 16 | Mono output volume word |
| vol_beep | output | 16 | Beep input level word |
| vol_phone | output | 16 | Phone input gain word |
| vol_mic | output | 16 | Mic input gain word |
| vol_line | output | 16 | Line input gain word |
| vol_cd | output | 16 | CD input gain word |
| vol_pcm | output | 16 | PCM output gain word |
| rec_gain | output | 16 | Record gain word |
| rec_sel_l | output | 3 | Left record source |
| rec_sel_r | output | 3 | Right record source |
| pcm_post_enh | output | 1 | PCM path after stereo enhance |
| enh_en | output | 1 | Stereo enhance enable |
| mono_src_mic | output | 1 | Mono output takes mic |
| mic_src_2 | output | 1 | Second mic selected |
| adc_dac_loop | output | 1 | ADC-to-DAC loopback |
| vra_en | output | 1 | Variable-rate enable |
| dac_rate | output | 16 | DAC sample rate |
| adc_rate | output | 16 | ADC sample rate |
| pwrdn | output | 7 | Powerdown controls |

## Verification
The bench sets every writable register to all ones and reads it back. A missing or widened mask then shows as wrong set bits, and an X bit that kept data shows as a nonzero reserved field. It writes to the read-only, fixed and odd indices, then re-reads a neighbouring register and watches the control outputs. A decoder that aliased on the low index bit, or that let 28h or 22h store data, would corrupt them. It makes a read and a write in the same cycle, so a design that returns the freshly written value fails. It performs the soft reset after many changes and checks that storage, the variable-rate flag and the record selects all return to their defaults, and that the live ready and ID inputs still appear.

// File: rtl/creg_pkg.sv
`timescale 1ns/1ps
package creg_pkg;
    localparam int DW     = 16;
    localparam int IW     = 7;
    localparam int RDY_W  = 4;
    localparam int ID_W   = 2;
    localparam int NSLOT  = 15;
    localparam int PD_W   = 7;

    typedef logic [DW-1:0] word_t;
    typedef logic [IW-1:0] idx_t;

    typedef enum logic [0:0] {ST_IDLE, ST_RESP} rd_state_e;

    localparam idx_t IX_SOFTRST = 7'h00;
    localparam idx_t IX_PWR     = 7'h26;
    localparam idx_t IX_EXTID   = 7'h28;
    localparam word_t CAPS_WORD = 16'h0D50;

    // slot numbers
    localparam int SL_MASTER = 0,  SL_MONO = 1,  SL_BEEP = 2,  SL_PHONE = 3;
    localparam int SL_MIC    = 4,  SL_LINE = 5,  SL_CD   = 6,  SL_PCM   = 7;
    localparam int SL_RSEL   = 8,  SL_RGAIN = 9, SL_GP   = 10, SL_PWR   = 11;
    localparam int SL_XCTL   = 12, SL_DRATE = 13, SL_ARATE = 14;

    function automatic idx_t slot_idx(input int s);
        case (s)
            SL_MASTER: return 7'h02;
            SL_MONO:   return 7'h06;
            SL_BEEP:   return 7'h0A;
            SL_PHONE:  return 7'h0C;
            SL_MIC:    return 7'h0E;
            SL_LINE:   return 7'h10;
            SL_CD:     return 7'h12;
            SL_PCM:    return 7'h18;
            SL_RSEL:   return 7'h1A;
            SL_RGAIN:  return 7'h1C;
            SL_GP:     return 7'h20;
            SL_PWR:    return 7'h26;
            SL_XCTL:   return 7'h2A;
            SL_DRATE:  return 7'h2C;
            default:   return 7'h32;
        endcase
    endfunction

    function automatic word_t slot_dflt(input int s);
        case (s)
            SL_MASTER, SL_PHONE, SL_MIC:  return 16'h8008;
            SL_MONO, SL_RGAIN:            return 16'h8000;
            SL_LINE, SL_CD, SL_PCM:       return 16'h8808;
            SL_DRATE, SL_ARATE:           return 16'hBB80;
            default:                      return 16'h0000;
        endcase
    endfunction

    function automatic word_t slot_mask(input int s);
        case (s)
            SL_MASTER, SL_LINE, SL_CD, SL_PCM: return 16'h9F1F;
            SL_MONO, SL_PHONE:                 return 16'h801F;
            SL_BEEP:                           return 16'h801E;
            SL_MIC:                            return 16'h805F;
            SL_RSEL:                           return 16'h0707;
            SL_RGAIN:                          return 16'h8F0F;
            SL_GP:                             return 16'hA380;
            SL_PWR:                            return 16'h7F00;
            SL_XCTL:                           return 16'h0001;
            default:                           return 16'hFFFF;
        endcase
    endfunction
endpackage

// File: rtl/creg_decode.sv
`timescale 1ns/1ps
module creg_decode
    import creg_pkg::*;
(
    input  logic             wr_en,
    input  idx_t             idx,
    output logic [NSLOT-1:0] wr_hit,
    output logic             soft_clr
);
    for (genvar g = 0; g < NSLOT; g++) begin : g_hit
        assign wr_hit[g] = wr_en && (idx == slot_idx(g));
    end
    assign soft_clr = wr_en && (idx == IX_SOFTRST);
endmodule

// File: rtl/creg_store.sv
`timescale 1ns/1ps
module creg_store
    import creg_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      soft_clr,
    input  logic [NSLOT-1:0]          wr_hit,
    input  word_t                     wdata,
    output logic [NSLOT-1:0][DW-1:0]  slots
);
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        localparam word_t DFLT = slot_dflt(g);
        localparam word_t MASK = slot_mask(g);
        word_t q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= DFLT;
            else if (soft_clr)
                q <= DFLT;
            else if (wr_hit[g])
                q <= wdata & MASK;
        end
        assign slots[g] = q;
    end
endmodule

// File: rtl/creg_rdmux.sv
`timescale 1ns/1ps
module creg_rdmux
    import creg_pkg::*;
(
    input  idx_t                      idx,
    input  logic [NSLOT-1:0][DW-1:0]  slots,
    input  logic [ID_W-1:0]           id_pins,
    input  logic [RDY_W-1:0]          ready_in,
    output word_t                     rd_word
);
    always_comb begin
        rd_word = '0;
        for (int s = 0; s < NSLOT; s++) begin
            if (idx == slot_idx(s))
                rd_word = slots[s];
        end
        if (idx == IX_PWR)
            rd_word = rd_word | {{(DW-RDY_W){1'b0}}, ready_in};
        if (idx == IX_SOFTRST)
            rd_word = CAPS_WORD;
        if (idx == IX_EXTID)
            rd_word = {id_pins, {(DW-ID_W-1){1'b0}}, 1'b1};
    end
endmodule

// File: rtl/codec_ctrl_regs.sv
`timescale 1ns/1ps
module codec_ctrl_regs
    import creg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [6:0]  idx,
    input  logic [15:0] wdata,
    input  logic [1:0]  id_pins,
    input  logic [3:0]  ready_in,
    output logic [15:0] rd_data,
    output logic        rd_valid,
    output logic [15:0] vol_master,
    output logic [15:0] vol_mono,
    output logic [15:0] vol_beep,
    output logic [15:0] vol_phone,
    output logic [15:0] vol_mic,
    output logic [15:0] vol_line,
    output logic [15:0] vol_cd,
    output logic [15:0] vol_pcm,
    output logic [15:0] rec_gain,
    output logic [2:0]  rec_sel_l,
    output logic [2:0]  rec_sel_r,
    output logic        pcm_post_enh,
    output logic        enh_en,
    output logic        mono_src_mic,
    output logic        mic_src_2,
    output logic        adc_dac_loop,
    output logic        vra_en,
    output logic [15:0] dac_rate,
    output logic [15:0] adc_rate,
    output logic [6:0]  pwrdn
);
    logic [NSLOT-1:0]         wr_hit;
    logic                     soft_clr;
    logic [NSLOT-1:0][DW-1:0] slots;
    word_t                    rd_word;
    rd_state_e                state_q, state_d;
    word_t                    rd_q;

    creg_decode u_dec (
        .wr_en    (wr_en),
        .idx      (idx),
        .wr_hit   (wr_hit),
        .soft_clr (soft_clr)
    );

    creg_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .wr_hit   (wr_hit),
        .wdata    (wdata),
        .slots    (slots)
    );

    creg_rdmux u_mux (
        .idx      (idx),
        .slots    (slots),
        .id_pins  (id_pins),
        .ready_in (ready_in),
        .rd_word  (rd_word)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rd_q    <= '0;
        end else begin
            state_q <= state_d;
            if (rd_en)
                rd_q <= rd_word;
        end
    end

    // next state: issue / chain / retire / wait
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = rd_en ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_en ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rd_valid     = (state_q == ST_RESP);
        rd_data      = rd_q;
        vol_master   = slots[SL_MASTER];
        vol_mono     = slots[SL_MONO];
        vol_beep     = slots[SL_BEEP];
        vol_phone    = slots[SL_PHONE];
        vol_mic      = slots[SL_MIC];
        vol_line     = slots[SL_LINE];
        vol_cd       = slots[SL_CD];
        vol_pcm      = slots[SL_PCM];
        rec_gain     = slots[SL_RGAIN];
        rec_sel_l    = slots[SL_RSEL][10:8];
        rec_sel_r    = slots[SL_RSEL][2:0];
        pcm_post_enh = slots[SL_GP][15];
        enh_en       = slots[SL_GP][13];
        mono_src_mic = slots[SL_GP][9];
        mic_src_2    = slots[SL_GP][8];
        adc_dac_loop = slots[SL_GP][7];
        vra_en       = slots[SL_XCTL][0];
        dac_rate     = slots[SL_DRATE];
        adc_rate     = slots[SL_ARATE];
        pwrdn        = slots[SL_PWR][8 +: PD_W];
    end
endmodule

// File: rtl/creg_chk.sv
`timescale 1ns/1ps
module creg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        rd_en,
    input logic [6:0]  idx,
    input logic [15:0] wdata,
    input logic [15:0] rd_data,
    input logic        rd_valid,
    input logic        vra_en,
    input logic [2:0]  rec_sel_l,
    input logic [15:0] vol_master,
    input logic [15:0] dac_rate
);
    // R9
    rd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    // R9
    rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
    // R2
    soft_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == 7'h00) |=> (vol_master == 16'h8008 && dac_rate == 16'hBB80));
    // R2
    caps_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && idx == 7'h00) |=> (rd_data == 16'h0D50));
    // R7
    fixed_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && idx == 7'h22) |=> (rd_data == 16'h0000));
    // R6
    vra_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == 7'h2A) |=> (vra_en == $past(wdata[0])));
    // R8
    rsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (idx == 7'h1A || idx == 7'h00)) |=> $stable(rec_sel_l));
endmodule

bind codec_ctrl_regs creg_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .idx        (idx),
    .wdata      (wdata),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .vra_en     (vra_en),
    .rec_sel_l  (rec_sel_l),
    .vol_master (vol_master),
    .dac_rate   (dac_rate)
);

// File: tb/codec_ctrl_regs_tb_top.sv
`timescale 1ns/1ps
module codec_ctrl_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [6:0]  idx = '0;
    logic [15:0] wdata = '0;
    logic [1:0]  id_pins = 2'b00;
    logic [3:0]  ready_in = 4'b0000;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic [15:0] vol_master, vol_mono, vol_beep, vol_phone, vol_mic;
    logic [15:0] vol_line, vol_cd, vol_pcm, rec_gain, dac_rate, adc_rate;
    logic [2:0]  rec_sel_l, rec_sel_r;
    logic        pcm_post_enh, enh_en, mono_src_mic, mic_src_2, adc_dac_loop, vra_en;
    logic [6:0]  pwrdn;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    codec_ctrl_regs dut_i (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [6:0] i, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; idx = i; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [6:0] i, input logic [15:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1; idx = i;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_rw(input logic [6:0] i, input logic [15:0] d, input logic [15:0] exp_old);
        @(negedge clk);
        rd_en = 1'b1; wr_en = 1'b1; idx = i; wdata = d;
        exp_q.push_back(exp_old); tag_q.push_back("R9 same-cycle read");
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
    endtask

    // monitor: pop and compare read results
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk("R9 unexpected rd_valid", 32'd1, 32'd0);
            end else begin
                chk(tag_q.pop_front(), {16'h0, rd_data}, {16'h0, exp_q.pop_front()});
            end
        end
    end

    initial begin
        #(8 * 200000);
        n_fail++; n_chk++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 rd_valid in reset", {31'h0, rd_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 rd_valid idle", {31'h0, rd_valid}, 32'h0);

        // R1 defaults
        do_read(7'h02, 16'h8008, "R1 02h");
        do_read(7'h06, 16'h8000, "R1 06h");
        do_read(7'h0A, 16'h0000, "R1 0Ah");
        do_read(7'h0C, 16'h8008, "R1 0Ch");
        do_read(7'h0E, 16'h8008, "R1 0Eh");
        do_read(7'h10, 16'h8808, "R1 10h");
        do_read(7'h12, 16'h8808, "R1 12h");
        do_read(7'h18, 16'h8808, "R1 18h");
        do_read(7'h1A, 16'h0000, "R1 1Ah");
        do_read(7'h1C, 16'h8000, "R1 1Ch");
        do_read(7'h20, 16'h0000, "R1 20h");
        do_read(7'h2C, 16'hBB80, "R1 2Ch");
        do_read(7'h32, 16'hBB80, "R1 32h");
        chk("R11 vol_line default", {16'h0, vol_line}, 32'h8808);

        // R3 masks
        do_write(7'h02, 16'hFFFF); do_read(7'h02, 16'h9F1F, "R3 02h mask");
        do_write(7'h0A, 16'hFFFF); do_read(7'h0A, 16'h801E, "R3 0Ah mask");
        do_write(7'h0E, 16'hFFFF); do_read(7'h0E, 16'h805F, "R3 0Eh mask");
        do_write(7'h1C, 16'hFFFF); do_read(7'h1C, 16'h8F0F, "R3 1Ch mask");
        do_write(7'h20, 16'hFFFF); do_read(7'h20, 16'hA380, "R3 20h mask");
        chk("R10 gp bits", {27'h0, pcm_post_enh, enh_en, mono_src_mic, mic_src_2, adc_dac_loop}, 32'h1F);
        do_write(7'h20, 16'h2100);
        chk("R10 gp partial", {27'h0, pcm_post_enh, enh_en, mono_src_mic, mic_src_2, adc_dac_loop}, 32'h0A);

        // R11 volumes
        do_write(7'h0E, 16'h0048);
        chk("R11 vol_mic", {16'h0, vol_mic}, 32'h0048);
        chk("R11 vol_master", {16'h0, vol_master}, 32'h9F1F);
        chk("R11 rec_gain", {16'h0, rec_gain}, 32'h8F0F);

        // R10 record select and rates
        do_write(7'h1A, 16'hFD0B);
        chk("R10 rec_sel_l", {29'h0, rec_sel_l}, 32'd5);
        chk("R10 rec_sel_r", {29'h0, rec_sel_r}, 32'd3);
        do_write(7'h2C, 16'h1F40);
        do_write(7'h32, 16'h5622);
        chk("R10 dac_rate", {16'h0, dac_rate}, 32'h1F40);
        chk("R10 adc_rate", {16'h0, adc_rate}, 32'h5622);

        // R4 power register
        ready_in = 4'b1010;
        do_write(7'h26, 16'hFFFF);
        do_read(7'h26, 16'h7F0A, "R4 26h read");
        chk("R4 pwrdn", {25'h0, pwrdn}, 32'h7F);
        ready_in = 4'b0101;
        do_write(7'h26, 16'h00FF);
        do_read(7'h26, 16'h0005, "R4 26h low byte ignored");

        // R5 ext ID
        id_pins = 2'b10;
        do_read(7'h28, 16'h8001, "R5 28h id=10");
        do_write(7'h28, 16'h0000);
        id_pins = 2'b01;
        do_read(7'h28, 16'h4001, "R5 28h write ignored");

        // R6 ext control
        do_write(7'h2A, 16'hFFFF);
        do_read(7'h2A, 16'h0001, "R6 2Ah");
        chk("R6 vra_en set", {31'h0, vra_en}, 32'h1);
        do_write(7'h2A, 16'hFFFE);
        chk("R6 vra_en clear", {31'h0, vra_en}, 32'h0);

        // R7 fixed register
        do_write(7'h22, 16'hFFFF);
        do_read(7'h22, 16'h0000, "R7 22h");

        // R8 unimplemented indices
        do_write(7'h03, 16'hFFFF);
        do_write(7'h1B, 16'h0000);
        do_write(7'h24, 16'hFFFF);
        do_read(7'h03, 16'h0000, "R8 03h");
        do_read(7'h24, 16'h0000, "R8 24h");
        do_read(7'h1A, 16'h0503, "R8 1Ah untouched");
        do_read(7'h02, 16'h9F1F, "R8 02h untouched");
        chk("R8 rec_sel_l kept", {29'h0, rec_sel_l}, 32'd5);

        // R9 same-cycle read and write
        do_rw(7'h0C, 16'h0011, 16'h8008);
        do_read(7'h0C, 16'h0011, "R9 write landed");
        @(negedge clk);
        rd_en = 1'b1; idx = 7'h2C;
        exp_q.push_back(16'h1F40); tag_q.push_back("R9 back-to-back a");
        @(negedge clk);
        idx = 7'h32;
        exp_q.push_back(16'h5622); tag_q.push_back("R9 back-to-back b");
        @(negedge clk);
        rd_en = 1'b0;

        // R2 soft reset
        ready_in = 4'b1111;
        id_pins = 2'b11;
        do_write(7'h00, 16'h1234);
        chk("R2 vol_master", {16'h0, vol_master}, 32'h8008);
        chk("R2 vra_en", {31'h0, vra_en}, 32'h0);
        chk("R2 rec_sel_l", {29'h0, rec_sel_l}, 32'd0);
        chk("R2 pwrdn", {25'h0, pwrdn}, 32'h0);
        do_read(7'h2C, 16'hBB80, "R2 2Ch");
        do_read(7'h0E, 16'h8008, "R2 0Eh");
        do_read(7'h20, 16'h0000, "R2 20h");
        do_read(7'h26, 16'h000F, "R2 26h ready live");
        do_read(7'h28, 16'hC001, "R2 28h id live");
        do_read(7'h00, 16'h0D50, "R2 caps word");

        repeat (3) @(negedge clk);
        chk("R9 queue drained", exp_q.size(), 32'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule